// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Register

This block is a serial test port for a chip that has separate input and output pins. A tester drives it with a test clock, a mode-select line and a serial data input. A standard sixteen-state controller runs on the rising test-clock edge. It moves data through one of four shift paths: a 3-bit instruction path, a 1-bit bypass path, a 32-bit identification path and a 109-stage boundary path. The serial output is registered on the falling edge. There is no separate test-reset pin. The controller returns to its reset state on the power-up reset, or after five rising edges with the mode-select line held high.

The boundary path has 108 pin cells plus one internal control cell at its far end, next to the serial input. Three instructions select the boundary path. One of them drives all outputs to high impedance while the pins are sampled. A second only samples the pins. The third, the external test, also holds the outputs at high impedance, unless the control cell was set when that instruction was loaded. The block gives capture and update strobes and a parallel update word to the boundary cells around it. The mapping from cells to pins belongs to that surrounding logic.

Top module: `scan_tap_ctl`

## Requirements
- R1: The power-up reset (rst_n low at a rising edge) and five consecutive rising edges with tms high, from any state, both put the controller in its reset state. The reset state selects the identification instruction, so out_hiz is 0 and tdo_oe is 0.
- R2: In the reset state the active instruction becomes identification. A data scan then shifts out, LSB first, the 32-bit word {rev[2:0], cfg[16:0], mfg[10:0], 1'b1}. With the default parameters this word is rev=3'b010, cfg=17'h0B6C5 and mfg=11'h0D5.
- R3: The capture step of an instruction scan loads the pattern 3'b001, so the first three bits shifted out are 1, 0, 0. The 3 bits shifted in become the active instruction at the instruction-update state.
- R4: The instruction codes are 000 external test, 001 identification, 010 sample-with-high-Z, 100 sample and 111 bypass. The unassigned codes 011, 101 and 110 behave exactly as bypass.
- R5: Under bypass (or an unassigned code) the data path is one stage long, and the capture step loads 0 into it. The stage is also cleared at the instruction update that selects bypass. It holds the last bit shifted in.
- R6: Under the three boundary instructions, the data capture step loads pin_in into cells 107..0 and leaves the control cell unchanged. Cell 0 is shifted out first. Under sample and external test the serial input feeds the control cell (109 stages). Under sample-with-high-Z it feeds cell 107 (108 stages).
- R7: out_hiz is 1 under sample-with-high-Z. It is 0 under sample, identification and bypass. Under external test it is 1 unless the control cell held 1 at the instruction update that loaded the instruction.
- R8: The control cell changes only while sample or external test is active. A new value shifted into it has no effect on out_hiz until the next instruction update.
- R9: Under a boundary instruction, bsr_capture is high during the data capture state and bsr_update is high during the data update state. At the update edge, bsr_data takes cells 107..0. Under other instructions both strobes stay low and bsr_data keeps its value.
- R10: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is 1 exactly while the controller is in the instruction-shift or data-shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pin_in | input | 108 | Pin values offered to the boundary capture |
| tdo | output | 1 | Serial data out, falling-edge register |
| tdo_oe | output | 1 | Serial output enable, high in the shift states |
| out_hiz | output | 1 | Request to put the chip outputs in high impedance |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_update | output | 1 | Boundary update strobe |
| bsr_data | output | 108 | Boundary update word |

## Verification
Two effects can land on the same rising edge. One is the instruction update that latches the high-impedance override from the control cell. The other is a shift that writes a new value into that control cell. The bench shifts a 1 into the control cell under external test and confirms that out_hiz stays high. It then reloads the same instruction and confirms that the output now drives, with sample-with-high-Z scans in between to show that the cell is left alone. Each scan result is compared with a bench model of the capture word, the path length and the resulting update word, under directed and seeded random instruction sequences.

// File: rtl/scan_tap_pkg.sv
// Shared types for the test access port: controller states, instruction
// codes and the decoded operation. Assumes a 3-bit instruction register.
package scan_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        OP_EXTEST, OP_IDCODE, OP_SAMPLEZ, OP_SAMPLE, OP_BYPASS
    } tap_op_e;

    localparam logic [IR_W-1:0] CODE_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] CODE_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] CODE_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] CODE_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] CODE_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE   = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller clocked on rising tck.
// Assumes: rst_n is the only reset; holding tms high resets it in five edges.
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;
    logic [2:0] hi_run;

    // Next-state selection from tms.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous power-up reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Saturating count of consecutive tms-high edges, for the check below.
    always_ff @(posedge tck) begin
        if (!rst_n)       hi_run <= 3'd0;
        else if (!tms)    hi_run <= 3'd0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Instruction shift/hold registers, decode and the high-Z request.
// Assumes unassigned codes fall back to bypass; the external-test drive
// permission is sampled from the control cell at each instruction update.
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  logic       tdi,
    input  logic       ctl_bit,
    output logic       ir_tdo,
    output tap_op_e    op,
    output logic       byp_clr,
    output logic       out_hiz
);

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    logic            ext_drive;

    function automatic tap_op_e decode(input logic [IR_W-1:0] c);
        case (c)
            CODE_EXTEST:  decode = OP_EXTEST;
            CODE_IDCODE:  decode = OP_IDCODE;
            CODE_SAMPLEZ: decode = OP_SAMPLEZ;
            CODE_SAMPLE:  decode = OP_SAMPLE;
            default:      decode = OP_BYPASS;
        endcase
    endfunction

    // Instruction shift register: capture fixed pattern, shift LSB out.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_sr <= CODE_IDCODE;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: identification on reset, new code on update.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= CODE_IDCODE;
        else if (state == ST_UPD_IR)     ir_q <= ir_sr;
    end

    // Drive permission for external test, taken at instruction update.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ext_drive <= 1'b0;
        else if (state == ST_UPD_IR) ext_drive <= ctl_bit;
    end

    assign op      = decode(ir_q);
    assign ir_tdo  = ir_sr[0];
    assign byp_clr = (state == ST_UPD_IR) && (decode(ir_sr) == OP_BYPASS);
    assign out_hiz = (op == OP_SAMPLEZ) || ((op == OP_EXTEST) && !ext_drive);

    // R2
    reset_loads_id_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (op == OP_IDCODE));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

    // R8
    drive_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR) |=> $stable(ext_drive));

endmodule

// File: rtl/tap_dr.sv
// Data-side registers: bypass stage, identification word and the boundary
// chain (pin cells plus one internal control cell at the input end).
// Assumes the decoded operation is stable outside instruction update.
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter logic [2:0]  ID_REV  = 3'b010,
    parameter logic [16:0] ID_CFG  = 17'h0B6C5,
    parameter logic [10:0] ID_MFG  = 11'h0D5
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  tap_op_e            op,
    input  logic               tdi,
    input  logic               byp_clr,
    input  logic [BSR_LEN-2:0] pin_in,
    output logic               dr_tdo,
    output logic               ctl_bit,
    output logic               bsr_capture,
    output logic               bsr_update,
    output logic [BSR_LEN-2:0] bsr_data
);

    localparam int PIN_W = BSR_LEN - 1;
    localparam int ID_W  = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_CFG, ID_MFG, 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            ctl_q;
    logic [PIN_W-1:0] cell_sr;
    logic [PIN_W-1:0] cell_upd;
    logic            bsel, zmode, ctl_wr, cap_en, sh_en, upd_en;

    assign bsel   = (op == OP_EXTEST) || (op == OP_SAMPLE) || (op == OP_SAMPLEZ);
    assign zmode  = (op == OP_SAMPLEZ);
    assign ctl_wr = (op == OP_EXTEST) || (op == OP_SAMPLE);
    assign cap_en = bsel && (state == ST_CAP_DR);
    assign sh_en  = bsel && (state == ST_SH_DR);
    assign upd_en = bsel && (state == ST_UPD_DR);

    // Bypass stage: cleared on select or capture, follows tdi when shifting.
    always_ff @(posedge tck) begin
        if (!rst_n || byp_clr) byp_q <= 1'b0;
        else if (op == OP_BYPASS && state == ST_CAP_DR) byp_q <= 1'b0;
        else if (op == OP_BYPASS && state == ST_SH_DR)  byp_q <= tdi;
    end

    // Identification shift register.
    always_ff @(posedge tck) begin
        if (!rst_n) id_sr <= ID_WORD;
        else if (op == OP_IDCODE && state == ST_CAP_DR) id_sr <= ID_WORD;
        else if (op == OP_IDCODE && state == ST_SH_DR)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Internal control cell: written only under sample or external test.
    always_ff @(posedge tck) begin
        if (!rst_n)                ctl_q <= 1'b0;
        else if (sh_en && ctl_wr)  ctl_q <= tdi;
    end

    // Boundary pin cells, one shift stage and one update stage each.
    for (genvar i = 0; i < PIN_W; i++) begin : g_cell
        logic src, sr_q, upd_q;
        if (i == PIN_W - 1) begin : g_top
            assign src = zmode ? tdi : ctl_q;
        end else begin : g_mid
            assign src = cell_sr[i+1];
        end
        // Capture the pin or shift toward cell 0.
        always_ff @(posedge tck) begin
            if (!rst_n)      sr_q <= 1'b0;
            else if (cap_en) sr_q <= pin_in[i];
            else if (sh_en)  sr_q <= src;
        end
        // Parallel update stage.
        always_ff @(posedge tck) begin
            if (!rst_n)      upd_q <= 1'b0;
            else if (upd_en) upd_q <= sr_q;
        end
        assign cell_sr[i]  = sr_q;
        assign cell_upd[i] = upd_q;
    end

    // Serial output of the selected data path.
    always_comb begin
        case (op)
            OP_IDCODE: dr_tdo = id_sr[0];
            OP_BYPASS: dr_tdo = byp_q;
            default:   dr_tdo = cell_sr[0];
        endcase
    end

    assign ctl_bit     = ctl_q;
    assign bsr_capture = cap_en;
    assign bsr_update  = upd_en;
    assign bsr_data    = cell_upd;

    // R5
    bypass_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
        byp_clr |=> (byp_q == 1'b0));

    // R6
    pin_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        cap_en |=> (cell_sr == $past(pin_in)));

    // R8
    ctl_guard_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !((op == OP_EXTEST) || (op == OP_SAMPLE)) |=> $stable(ctl_q));

    // R9
    update_copy_chk: assert property (@(posedge tck) disable iff (!rst_n)
        upd_en |=> (bsr_data == $past(cell_sr)));

endmodule

// File: rtl/scan_tap_ctl.sv
// Top of the test access port: controller, instruction side, data side
// and the falling-edge serial output stage.
// Assumes tck is free-running while rst_n is low.
module scan_tap_ctl
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter logic [2:0]  ID_REV  = 3'b010,
    parameter logic [16:0] ID_CFG  = 17'h0B6C5,
    parameter logic [10:0] ID_MFG  = 11'h0D5
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-2:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               out_hiz,
    output logic               bsr_capture,
    output logic               bsr_update,
    output logic [BSR_LEN-2:0] bsr_data
);

    tap_state_e state;
    tap_op_e    op;
    logic       ir_tdo, dr_tdo, ctl_bit, byp_clr;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (state),
        .tdi     (tdi),
        .ctl_bit (ctl_bit),
        .ir_tdo  (ir_tdo),
        .op      (op),
        .byp_clr (byp_clr),
        .out_hiz (out_hiz)
    );

    tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_REV  (ID_REV),
        .ID_CFG  (ID_CFG),
        .ID_MFG  (ID_MFG)
    ) u_dr (
        .tck         (tck),
        .rst_n       (rst_n),
        .state       (state),
        .op          (op),
        .tdi         (tdi),
        .byp_clr     (byp_clr),
        .pin_in      (pin_in),
        .dr_tdo      (dr_tdo),
        .ctl_bit     (ctl_bit),
        .bsr_capture (bsr_capture),
        .bsr_update  (bsr_update),
        .bsr_data    (bsr_data)
    );

    // Falling-edge output register and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo    <= (state == ST_SH_IR) ? ir_tdo :
                      (state == ST_SH_DR) ? dr_tdo : 1'b0;
        end
    end

    // R10
    oe_in_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> ((state == ST_SH_IR) || (state == ST_SH_DR)));

endmodule

// File: tb/scan_tap_ctl_tb.sv
module scan_tap_ctl_tb;

    localparam logic [31:0] ID_EXP = {3'b010, 17'h0B6C5, 11'h0D5, 1'b1};

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [107:0] pins = '0;
    logic         tdo, tdo_oe, out_hiz, bsr_capture, bsr_update;
    logic [107:0] bsr_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    bit  oe_bad = 0, mid_bad = 0, cap_seen = 0, upd_seen = 0;

    // Bench model of the block's visible state.
    logic [2:0]   m_op = 3'd1;
    logic         m_ctl = 1'b0;
    logic         m_ext = 1'b0;
    logic [107:0] m_data = '0;

    always #10 tck = ~tck;

    scan_tap_ctl u_dut (
        .tck (tck), .rst_n (rst_n), .tms (tms), .tdi (tdi), .pin_in (pins),
        .tdo (tdo), .tdo_oe (tdo_oe), .out_hiz (out_hiz),
        .bsr_capture (bsr_capture), .bsr_update (bsr_update), .bsr_data (bsr_data)
    );

    function automatic logic [2:0] eff(input logic [2:0] c);
        eff = (c == 3'd0 || c == 3'd1 || c == 3'd2 || c == 3'd4) ? c : 3'd7;
    endfunction

    function automatic int plen(input logic [2:0] o);
        case (o)
            3'd1: plen = 32;
            3'd7: plen = 1;
            3'd2: plen = 108;
            default: plen = 109;
        endcase
    endfunction

    function automatic logic exp_hiz();
        exp_hiz = (m_op == 3'd2) || (m_op == 3'd0 && !m_ext);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t_ms, input logic t_di, input logic want_oe, output logic t_do);
        tms = t_ms;
        tdi = t_di;
        t_do = tdo;
        if (tdo_oe !== want_oe) oe_bad = 1;
        if (bsr_capture) cap_seen = 1;
        if (bsr_update) upd_seen = 1;
        @(posedge tck); #1;
        if (tdo !== t_do) mid_bad = 1;
        @(negedge tck); #1;
    endtask

    task automatic do_ir(input logic [2:0] code);
        logic [2:0] q;
        logic d;
        step(1, 0, 0, d); step(1, 0, 0, d); step(0, 0, 0, d); step(0, 0, 0, d);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], 1, d);
            q[i] = d;
        end
        step(1, 0, 0, d); step(0, 0, 0, d);
        m_ext = m_ctl;
        m_op  = eff(code);
        chk(q == 3'b001, "R3 ir capture", {125'd0, q}, 128'd1);
        chk(out_hiz == exp_hiz(), "R7 hiz after instruction", {127'd0, out_hiz}, {127'd0, exp_hiz()});
    endtask

    task automatic do_dr(input int n, input logic [127:0] din, input string tag);
        logic [127:0] q, e, cap;
        logic d;
        int L;
        bit bsel;
        q = '0; e = '0; cap = '0;
        cap_seen = 0; upd_seen = 0;
        L = plen(m_op);
        bsel = (m_op == 3'd0 || m_op == 3'd2 || m_op == 3'd4);
        if (m_op == 3'd1) cap[31:0] = ID_EXP;
        else if (bsel) begin
            cap[107:0] = pins;
            if (L == 109) cap[108] = m_ctl;
        end
        step(1, 0, 0, d); step(0, 0, 0, d); step(0, 0, 0, d);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], 1, d);
            q[i] = d;
            e[i] = (i < L) ? cap[i] : din[i - L];
        end
        step(1, 0, 0, d); step(0, 0, 0, d);
        chk(q == e, tag, q, e);
        if (bsel) begin
            for (int k = 0; k < 108; k++) m_data[k] = din[n - L + k];
            if (L == 109) m_ctl = din[n - 1];
        end
        chk(bsr_data == m_data, "R9 update word", {20'd0, bsr_data}, {20'd0, m_data});
        chk(cap_seen == bsel && upd_seen == bsel, "R9 strobes",
            {126'd0, cap_seen, upd_seen}, {126'd0, bsel, bsel});
    endtask

    function automatic logic [127:0] rnd128();
        rnd128 = {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic d;
        logic [127:0] v;
        logic [2:0] c;
        void'($urandom(32'd4242));
        @(negedge tck); #1;
        for (int i = 0; i < 4; i++) step(1, 0, 0, d);
        rst_n = 1'b1;
        // R1 reset state
        chk(out_hiz == 1'b0 && tdo_oe == 1'b0, "R1 reset outputs", {126'd0, out_hiz, tdo_oe}, 128'd0);
        chk(bsr_data == '0, "R9 reset update word", {20'd0, bsr_data}, 128'd0);
        step(0, 0, 0, d);
        do_dr(35, rnd128(), "R2 id word");
        // R5 bypass
        do_ir(3'b111);
        do_dr(10, rnd128(), "R5 bypass path");
        // R4 unassigned codes
        do_ir(3'b011); do_dr(6, rnd128(), "R4 code 011");
        do_ir(3'b101); do_dr(6, rnd128(), "R4 code 101");
        do_ir(3'b110); do_dr(6, rnd128(), "R4 code 110");
        // R6 sample, control cell cleared
        pins = rnd128();
        do_ir(3'b100);
        chk(out_hiz == 1'b0, "R7 sample drives", {127'd0, out_hiz}, 128'd0);
        v = rnd128(); v[111] = 1'b0;
        do_dr(112, v, "R6 sample chain");
        // R7/R8 external test: new control value waits for instruction update
        do_ir(3'b000);
        chk(out_hiz == 1'b1, "R7 extest default hiz", {127'd0, out_hiz}, 128'd1);
        pins = rnd128();
        v = rnd128(); v[111] = 1'b1;
        do_dr(112, v, "R6 extest chain");
        chk(out_hiz == 1'b1, "R8 hiz held until update", {127'd0, out_hiz}, 128'd1);
        do_ir(3'b000);
        chk(out_hiz == 1'b0, "R8 extest drives after reload", {127'd0, out_hiz}, 128'd0);
        // R6/R8 sample-with-high-Z: 108 stages, control cell untouched
        pins = rnd128();
        do_ir(3'b010);
        chk(out_hiz == 1'b1, "R7 samplez hiz", {127'd0, out_hiz}, 128'd1);
        do_dr(111, rnd128(), "R6 samplez chain");
        do_ir(3'b000);
        chk(out_hiz == 1'b0, "R8 ctl kept through samplez", {127'd0, out_hiz}, 128'd0);
        // R1 tms-high reset from the data-shift state
        do_ir(3'b111);
        step(1, 0, 0, d); step(0, 0, 0, d); step(0, 0, 0, d);
        step(1, 0, 1, d); step(1, 0, 0, d); step(1, 0, 0, d); step(1, 0, 0, d); step(1, 0, 0, d);
        step(0, 0, 0, d);
        m_op = 3'd1;
        chk(out_hiz == 1'b0 && tdo_oe == 1'b0, "R1 tms reset", {126'd0, out_hiz, tdo_oe}, 128'd0);
        do_dr(33, rnd128(), "R1 R2 id after tms reset");
        // random instruction sequences
        for (int it = 0; it < 24; it++) begin
            c = 3'($urandom % 8);
            pins = rnd128();
            do_ir(c);
            do_dr(plen(m_op) + 1 + int'($urandom % 4), rnd128(), "R4 R5 R6 random scan");
        end
        // R10 output timing and enable
        chk(mid_bad == 0, "R10 tdo held past rising edge", {127'd0, mid_bad}, 128'd0);
        chk(oe_bad == 0, "R10 tdo_oe only in shift", {127'd0, oe_bad}, 128'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule